// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter with Fault Break

This stage sits between a PWM generator and the gate drivers of a three-phase half-bridge. For each phase it takes one reference level and drives two gates: a high-side gate that follows the reference and a low-side gate that follows its inverse. Whenever the reference changes, both gates of that phase go off first. The gate that is about to switch on waits for a programmable number of clock cycles, so the two transistors of a leg never conduct at the same time. A reference pulse that is no longer than the dead time never reaches either gate.

A fault path overrides all six gates. It is fed by an external fault pin and by a clock-failure indication, and it can be enabled or disabled as a whole. While an enabled fault source is active, every gate takes a configured safe level. This override is pure logic between the inputs and the outputs, so it still works when the clock has stopped. A fault also sets a sticky status flag on the next clock edge. The gates stay at their safe levels until software clears the flag and then re-arms the outputs by taking the enable low and high again.

Every input is a level that is sampled on each clock. There is no data stream at this block's edge, so no valid/ready handshake exists and no back-pressure applies.

Top module: `dtb_gate_drive`

## Requirements
- R1: After a phase reference rises, that phase's low-side gate is off from the next clock edge. The high-side gate turns on D edges later, where D is the dead-time count in clock cycles.
- R2: After a phase reference falls, that phase's high-side gate is off from the next clock edge. The low-side gate turns on D edges later.
- R3: While the outputs are running, no phase ever has its high-side and low-side gates on at the same time.
- R4: A reference pulse held for W sampled edges drives its gate on for max(0, W-D) cycles. A pulse with W ≤ D is suppressed entirely.
- R5: With a dead-time count of zero, both gates of a phase swap one edge after the reference changes, with no gap between them.
- R6: While the fault enable is high and the fault pin is high, the high-side gates equal the safe-high setting and the low-side gates equal the safe-low setting. This happens in the same cycle and without any clock edge.
- R7: The clock-failure input, when the fault enable is high, forces the same safe pattern as the fault pin.
- R8: While the fault enable is low, both fault sources have no effect on the gates or on the status flag.
- R9: An active enabled fault source sets the status flag at the next clock edge. The flag holds until a clear is sampled while no fault source is active. A clear sampled during an active fault is ignored.
- R10: After a fault, the gates stay safe even once the flag is cleared. They run again only after the output enable has been sampled low at least once and is then high with the flag clear.
- R11: While the output enable is low, all gates show the safe pattern.
- R12: After reset the status flag is 0, and the gates show the safe pattern while the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; dead time is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_ref_i | input | 3 | Per-phase reference level from the PWM generator |
| dead_i | input | 8 | Dead-time count in clock cycles |
| safe_hi_i | input | 3 | Level each high-side gate takes when forced safe |
| safe_lo_i | input | 3 | Level each low-side gate takes when forced safe |
| flt_en_i | input | 1 | Enables the fault path |
| flt_pin_i | input | 1 | External fault request, active high |
| clk_fail_i | input | 1 | Clock-failure indication, active high |
| flt_clr_i | input | 1 | Request to clear the fault status flag |
| out_en_i | input | 1 | Master output enable; low-then-high re-arms after a fault |
| gate_hi_o | output | 3 | High-side gate drives |
| gate_lo_o | output | 3 | Low-side gate drives |
| flt_flag_o | output | 1 | Sticky fault status flag |

## Verification
Two pairs of functions can fall in the same cycle. The first is a fault arriving on the very edge where a dead-time countdown expires: the bench raises the fault pin during the cycle before that expiry edge. The test passes if the gate that was about to turn on instead shows its safe level, and if the flag latches. The second is a flag clear sampled on the same edge as a live fault source: the clear must lose to the fault and the flag must stay set. Both cases are also hit at random, where short fault pulses, clears and enable drops overlap with reference edges. On every cycle the outputs are compared against a behavioural model of the gates and the flag.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

  localparam int PHASES_DEF = 3;
  localparam int DEAD_W_DEF = 8;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

endpackage

// File: rtl/dtb_dead_chan.sv
module dtb_dead_chan #(
  parameter int DEAD_W = dtb_pkg::DEAD_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_i,
  input  logic [DEAD_W-1:0]    dead_i,
  output dtb_pkg::gate_pair_t  pair_o
);

  localparam logic [DEAD_W-1:0] ZERO = '0;

  logic              goal_q;
  logic [DEAD_W-1:0] wait_q;
  logic              settled;

  assign settled = (wait_q == ZERO);

  // A change of reference restarts the countdown; both gates stay off until it expires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      goal_q <= 1'b0;
      wait_q <= ZERO;
    end else if (ref_i != goal_q) begin
      goal_q <= ref_i;
      wait_q <= dead_i;
    end else if (!settled) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign pair_o.hi = goal_q & settled;
  assign pair_o.lo = ~goal_q & settled;

  // R1: a high-side turn-on with nonzero dead time follows a cycle with the low side off
  a_r1_hi_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pair_o.hi) && $past(dead_i) != ZERO) |-> $past(!pair_o.lo));

  // R2: mirror case for the low side
  a_r2_lo_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pair_o.lo) && $past(dead_i) != ZERO) |-> $past(!pair_o.hi));

  // R5: zero dead time swaps the pair on the next edge
  a_r5_zero_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_i == ZERO && ref_i != goal_q) |=> (pair_o.hi == $past(ref_i) && pair_o.lo == !$past(ref_i)));

endmodule

// File: rtl/dtb_break_ctl.sv
module dtb_break_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_en_i,
  input  logic flt_pin_i,
  input  logic clk_fail_i,
  input  logic flt_clr_i,
  input  logic out_en_i,
  output logic flt_now_o,
  output logic run_o,
  output logic flag_o
);

  logic flag_q;
  logic armed_q;

  // Purely combinational fault request: needs no clock edge to act.
  assign flt_now_o = flt_en_i & (flt_pin_i | clk_fail_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flt_now_o) begin
      flag_q <= 1'b1;
    end else if (flt_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (flt_now_o) begin
      armed_q <= 1'b0;
    end else if (!out_en_i) begin
      armed_q <= 1'b1;
    end
  end

  assign run_o  = out_en_i & armed_q & ~flag_q & ~flt_now_o;
  assign flag_o = flag_q;

  // R9: an active source latches the flag at the next edge
  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    flt_now_o |=> flag_o);

  // R9: without a clear the flag holds
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flt_clr_i) |=> flag_o);

  // R10: re-arming only follows a sampled low enable
  a_r10_rearm_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(!out_en_i));

endmodule

// File: rtl/dtb_out_mux.sv
module dtb_out_mux #(
  parameter int PHASES = dtb_pkg::PHASES_DEF
) (
  input  logic                              run_i,
  input  dtb_pkg::gate_pair_t [PHASES-1:0]  pairs_i,
  input  logic [PHASES-1:0]                 safe_hi_i,
  input  logic [PHASES-1:0]                 safe_lo_i,
  output logic [PHASES-1:0]                 gate_hi_o,
  output logic [PHASES-1:0]                 gate_lo_o
);

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign gate_hi_o[p] = run_i ? pairs_i[p].hi : safe_hi_i[p];
    assign gate_lo_o[p] = run_i ? pairs_i[p].lo : safe_lo_i[p];
  end

endmodule

// File: rtl/dtb_gate_drive.sv
module dtb_gate_drive #(
  parameter int PHASES = dtb_pkg::PHASES_DEF,
  parameter int DEAD_W = dtb_pkg::DEAD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] pwm_ref_i,
  input  logic [DEAD_W-1:0] dead_i,
  input  logic [PHASES-1:0] safe_hi_i,
  input  logic [PHASES-1:0] safe_lo_i,
  input  logic              flt_en_i,
  input  logic              flt_pin_i,
  input  logic              clk_fail_i,
  input  logic              flt_clr_i,
  input  logic              out_en_i,
  output logic [PHASES-1:0] gate_hi_o,
  output logic [PHASES-1:0] gate_lo_o,
  output logic              flt_flag_o
);

  dtb_pkg::gate_pair_t [PHASES-1:0] pairs;
  logic flt_now;
  logic run;

  for (genvar p = 0; p < PHASES; p++) begin : g_chan
    dtb_dead_chan #(.DEAD_W(DEAD_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_i  (pwm_ref_i[p]),
      .dead_i (dead_i),
      .pair_o (pairs[p])
    );
  end

  dtb_break_ctl u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_en_i   (flt_en_i),
    .flt_pin_i  (flt_pin_i),
    .clk_fail_i (clk_fail_i),
    .flt_clr_i  (flt_clr_i),
    .out_en_i   (out_en_i),
    .flt_now_o  (flt_now),
    .run_o      (run),
    .flag_o     (flt_flag_o)
  );

  dtb_out_mux #(.PHASES(PHASES)) u_mux (
    .run_i     (run),
    .pairs_i   (pairs),
    .safe_hi_i (safe_hi_i),
    .safe_lo_i (safe_lo_i),
    .gate_hi_o (gate_hi_o),
    .gate_lo_o (gate_lo_o)
  );

  // R3: while running, no leg conducts on both sides
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((gate_hi_o & gate_lo_o) == '0));

  // R6 / R7: an enabled fault forces the configured pattern
  a_r6_forced_safe: assert property (@(posedge clk) disable iff (!rst_n)
    flt_now |-> (gate_hi_o == safe_hi_i && gate_lo_o == safe_lo_i));

  // R11: disabled outputs show the safe pattern
  a_r11_disabled_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |-> (gate_hi_o == safe_hi_i && gate_lo_o == safe_lo_i));

endmodule

// File: tb/tb_dtb_gate_drive.sv
module tb_dtb_gate_drive;

  localparam int CH = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  bit   clk_run = 1'b1;
  always #4 if (clk_run) clk = ~clk;   // 125 MHz

  logic [CH-1:0] ref_s = '0;
  logic [CH-1:0] safe_hi = 3'b010;
  logic [CH-1:0] safe_lo = 3'b101;
  logic [DW-1:0] dead = '0;
  logic flt_pin = 0, clk_fail = 0, flt_en = 1, out_en = 0, flt_clr = 0;
  logic [CH-1:0] gh, gl;
  logic flag;

  dtb_gate_drive dut (
    .clk(clk), .rst_n(rst_n), .pwm_ref_i(ref_s), .dead_i(dead),
    .safe_hi_i(safe_hi), .safe_lo_i(safe_lo), .flt_en_i(flt_en),
    .flt_pin_i(flt_pin), .clk_fail_i(clk_fail), .flt_clr_i(flt_clr),
    .out_en_i(out_en), .gate_hi_o(gh), .gate_lo_o(gl), .flt_flag_o(flag)
  );

  int tests = 0, fails = 0;
  string phase = "R12 reset";
  bit done = 0;

  // Behavioural reference model
  bit m_goal [CH];
  int m_wait [CH];
  bit m_flag, m_arm;

  function automatic bit m_flt();
    return flt_en && (flt_pin || clk_fail);
  endfunction

  function automatic bit m_run();
    return out_en && m_arm && !m_flag && !m_flt();
  endfunction

  function automatic logic [CH-1:0] exp_hi();
    logic [CH-1:0] v;
    for (int i = 0; i < CH; i++) v[i] = m_run() ? (m_goal[i] && m_wait[i] == 0) : safe_hi[i];
    return v;
  endfunction

  function automatic logic [CH-1:0] exp_lo();
    logic [CH-1:0] v;
    for (int i = 0; i < CH; i++) v[i] = m_run() ? (!m_goal[i] && m_wait[i] == 0) : safe_lo[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) begin m_goal[i] = 0; m_wait[i] = 0; end
      m_flag = 0; m_arm = 1;
    end else begin
      bit f;
      f = m_flt();
      for (int i = 0; i < CH; i++) begin
        if (ref_s[i] != m_goal[i]) begin m_goal[i] = ref_s[i]; m_wait[i] = dead; end
        else if (m_wait[i] > 0) m_wait[i]--;
      end
      if (f) m_flag = 1; else if (flt_clr) m_flag = 0;
      if (f) m_arm = 0; else if (!out_en) m_arm = 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check({phase, " model hi"}, 32'(gh), 32'(exp_hi()));
      check({phase, " model lo"}, 32'(gl), 32'(exp_lo()));
      check({phase, " model flag"}, 32'(flag), 32'(m_flag));
    end
  end

  task automatic smp();
    @(negedge clk); #3;
  endtask

  task automatic pulse(int w, int expect_on);
    int on = 0;
    @(negedge clk) ref_s[1] = 1'b1;
    for (int j = 0; j < w + int'(dead) + 4; j++) begin
      @(negedge clk);
      if (j == w - 1) ref_s[1] = 1'b0;
      #3;
      on += int'(gh[1]);
    end
    check($sformatf("R4 pulse w=%0d on-cycles", w), 32'(on), 32'(expect_on));
    repeat (8) smp();
  endtask

  initial begin
    int n;
    int ovl;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    #3;
    check("R12 reset flag", 32'(flag), 0);
    check("R12 reset hi safe", 32'(gh), 32'(safe_hi));
    @(negedge clk) rst_n = 1'b1;
    smp();
    phase = "R11 disabled";
    check("R11 disabled hi", 32'(gh), 32'(safe_hi));
    check("R11 disabled lo", 32'(gl), 32'(safe_lo));

    phase = "R1 rise";
    dead = 8'd5; out_en = 1'b1;
    repeat (8) smp();
    check("R1 settled low sides", 32'(gl), 32'h7);
    @(negedge clk) ref_s[0] = 1'b1;
    n = 0;
    for (int k = 1; k <= 12; k++) begin
      smp();
      if (k == 1) check("R1 low side off at once", 32'(gl[0]), 0);
      if (n == 0 && gh[0]) n = k;
    end
    check("R1 high side turn-on sample", 32'(n), 6);

    phase = "R2 fall";
    @(negedge clk) ref_s[0] = 1'b0;
    n = 0;
    for (int k = 1; k <= 12; k++) begin
      smp();
      if (k == 1) check("R2 high side off at once", 32'(gh[0]), 0);
      if (n == 0 && gl[0]) n = k;
    end
    check("R2 low side turn-on sample", 32'(n), 6);

    phase = "R4 short pulses";
    pulse(5, 0);
    pulse(3, 0);
    pulse(8, 3);

    phase = "R5 zero dead";
    dead = 8'd0;
    repeat (3) smp();
    @(negedge clk) ref_s[2] = 1'b1;
    smp();
    check("R5 swap hi on", 32'(gh[2]), 1);
    check("R5 swap lo off", 32'(gl[2]), 0);
    @(negedge clk) ref_s[2] = 1'b0;
    smp();
    check("R5 swap hi off", 32'(gh[2]), 0);
    check("R5 swap lo on", 32'(gl[2]), 1);

    phase = "R3 random mix";
    dead = 8'd3; lf = 16'hACE1; ovl = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[1:0] == 2'b00) ref_s = ref_s ^ lf[6:4];
      flt_pin = (lf[11:7] == 5'd9);
      flt_clr = (lf[14:12] == 3'd2);
      out_en  = (lf[15:13] != 3'd0);
      #3;
      if (m_run() && (gh & gl) != '0) ovl++;
    end
    check("R3 no overlap while running", 32'(ovl), 0);

    phase = "R10 recover";
    @(negedge clk) begin flt_pin = 0; flt_clr = 1; out_en = 0; ref_s = 3'b011; dead = 8'd0; end
    smp();
    @(negedge clk) begin flt_clr = 0; out_en = 1; end
    repeat (3) smp();
    check("R10 running after re-arm", 32'(gh), 32'h3);

    phase = "R6 clock stopped";
    @(negedge clk);
    clk_run = 0;
    #1 flt_pin = 1'b1;
    #1 check("R6 forced hi, no clock", 32'(gh), 32'(safe_hi));
    check("R6 forced lo, no clock", 32'(gl), 32'(safe_lo));
    #1 flt_pin = 1'b0;
    #1 check("R6 released hi, no clock", 32'(gh), 32'h3);
    check("R6 released lo, no clock", 32'(gl), 32'h4);
    #1 clk_run = 1;

    phase = "R7 clock fail";
    @(negedge clk) clk_fail = 1'b1;
    #1 check("R7 forced hi", 32'(gh), 32'(safe_hi));
    smp();
    check("R9 flag set", 32'(flag), 1);
    @(negedge clk) flt_clr = 1'b1;
    smp();
    flt_clr = 1'b0;
    check("R9 clear during fault ignored", 32'(flag), 1);
    @(negedge clk) clk_fail = 1'b0;
    repeat (2) smp();
    check("R9 flag holds", 32'(flag), 1);
    @(negedge clk) flt_clr = 1'b1;
    smp();
    @(negedge clk) flt_clr = 1'b0;
    #3;
    check("R10 flag cleared", 32'(flag), 0);
    repeat (3) smp();
    check("R10 still safe before re-arm", 32'(gh), 32'(safe_hi));
    @(negedge clk) out_en = 1'b0;
    smp();
    @(negedge clk) out_en = 1'b1;
    smp();
    check("R10 running after low-high enable", 32'(gh), 32'h3);

    phase = "R8 fault disabled";
    @(negedge clk) begin flt_en = 0; flt_pin = 1; clk_fail = 1; end
    repeat (4) smp();
    check("R8 gates unaffected", 32'(gh), 32'h3);
    check("R8 flag unaffected", 32'(flag), 0);
    @(negedge clk) begin flt_pin = 0; clk_fail = 0; flt_en = 1; end

    phase = "R9 fault on expiry edge";
    dead = 8'd4;
    @(negedge clk) ref_s[0] = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk) flt_pin = 1'b1;
    #1 check("R6 fault at expiry hi", 32'(gh), 32'(safe_hi));
    @(negedge clk) begin flt_pin = 1'b0; flt_clr = 1'b1; end
    #3 check("R9 flag latched at expiry", 32'(flag), 1);
    @(negedge clk) flt_clr = 1'b0;
    repeat (3) smp();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule